// File: doc/BRIEF.md
# USB Controller Wrapper Control and Interrupt Register File

This block is a small register file that sits beside a USB host controller on a simple 32-bit register bus. Software writes configuration fields through it: a bus filter bypass, five port flags, a frame length adjust value, an endianness select, a coherency enable and a bus master enable. Each field drives an output port directly, so the logic that consumes these values sees a change on the clock edge that accepts the write.

The block also collects two error sources into one level interrupt. An address-decode error is raised by the block itself when software touches an offset that does not exist. A host system error is raised by a one-cycle pulse on an input pin. Each source has a status bit and a mask bit. Software never writes the mask directly. It writes ones to an enable offset to unmask sources, and ones to a disable offset to mask them. Status bits are cleared by writing one to them. The interrupt output is high while any status bit is set whose mask bit is clear.

Every access is a single request cycle. Only 4-byte accesses take effect. Read data comes back, with a valid strobe, on the cycle after the request.

Top module: `usbw_csr`

## Requirements
- R1: After reset every configuration output is 0, the status register reads 0x0, the mask register reads 0x3 (both sources masked) and `irq` is low.
- R2: Only an access with `bus_size` = 2 (4 bytes) takes effect. Any other size changes no register and sets no status bit, and a read of that size returns 0.
- R3: Configuration registers have these offsets and fields: 0x30 bits 3:0 filter bypass, 0x38 bits 5:0 frame adjust, 0x40 bit 0 big endian, 0x44 bit 0 coherency, 0x48 bit 0 bus master enable. Each one reads back its field with all other bits 0 and drives its output port.
- R4: The port register at 0x34 holds hub permanent attach at bit 0, power control present at bit 1, MSI enable at bit 2, SMI on command write at bit 3 and SMI on BAR write at bit 4. Each bit drives its own output.
- R5: `irq` is high exactly when some status bit is 1 and its mask bit is 0. It follows a change to status or mask on the same clock edge.
- R6: A one-cycle pulse on `hw_host_err` sets status bit 1 (status at 0x64), and the bit stays set until software clears it.
- R7: Writing to status at 0x64 clears each bit where the written value has a 1 and leaves the others. A set event on a bit in the same cycle as its clearing write wins, so the bit stays 1.
- R8: Writing to 0x6C clears the mask bits where the written value has ones. Writing to 0x70 sets the mask bits where the written value has ones. Both offsets read as 0.
- R9: The mask register at 0x68 can be read but not written. A write there changes nothing and is not a decode error.
- R10: A 4-byte read or write to an offset not listed above, or not 4-byte aligned, has no other effect. It returns 0 on a read and sets status bit 0.
- R11: `bus_rvalid` pulses on the cycle after a read request and carries the register value as it was on the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | log2 of access bytes; only 2 accepted |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| hw_host_err | input | 1 | Host system error event pulse |
| irq | output | 1 | Level interrupt |
| filt_bypass | output | 4 | Bus filter bypass field |
| hub_perm_attach | output | 1 | Hub permanent attach |
| pwr_ctrl_present | output | 1 | Power control present |
| msi_enable | output | 1 | MSI enable |
| smi_on_cmd_wr | output | 1 | SMI on command register write |
| smi_on_bar_wr | output | 1 | SMI on BAR write |
| frame_adj | output | 6 | Frame length adjust |
| big_endian | output | 1 | Endianness select |
| coherent_en | output | 1 | Coherency enable |
| bus_master_en | output | 1 | Bus master enable |

## Verification
A wrong mask or status bit shows up on `irq` on the edge that should have changed it. A hidden fault becomes visible no later than the next enable write, disable write or status read. A stuck or wrongly decoded configuration field shows directly on its output port and in the read-back one cycle later. Decode faults show as a status bit 0 that sets when it should not, or stays clear when it should set, right after the offending access. The race between a clearing write and an event is only seen if both land in the same cycle, so the bench drives that case on purpose.

// File: rtl/usbw_csr_pkg.sv
package usbw_csr_pkg;
    localparam int DATA_W   = 32;
    localparam int BYPASS_W = 4;
    localparam int PORT_W   = 5;
    localparam int FLADJ_W  = 6;
    localparam int NUM_SRC  = 2;

    localparam logic [7:0] OFF_BYPASS = 8'h30;
    localparam logic [7:0] OFF_PORT   = 8'h34;
    localparam logic [7:0] OFF_FLADJ  = 8'h38;
    localparam logic [7:0] OFF_ENDIAN = 8'h40;
    localparam logic [7:0] OFF_COHER  = 8'h44;
    localparam logic [7:0] OFF_BME    = 8'h48;
    localparam logic [7:0] OFF_STATUS = 8'h64;
    localparam logic [7:0] OFF_MASK   = 8'h68;
    localparam logic [7:0] OFF_EN     = 8'h6C;
    localparam logic [7:0] OFF_DIS    = 8'h70;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_BYPASS,
        SEL_PORT,
        SEL_FLADJ,
        SEL_ENDIAN,
        SEL_COHER,
        SEL_BME,
        SEL_STATUS,
        SEL_MASK,
        SEL_EN,
        SEL_DIS
    } reg_sel_e;

    typedef struct packed {
        logic [BYPASS_W-1:0] bypass;
        logic [PORT_W-1:0]   port;
        logic [FLADJ_W-1:0]  fladj;
        logic                endian;
        logic                coher;
        logic                bme;
    } cfg_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
    } irq_state_t;
endpackage

// File: rtl/usbw_csr_decode.sv
module usbw_csr_decode
    import usbw_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFF_W = 8;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFF_W-1:0] off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        sel = SEL_NONE;
        if      (hit(addr, OFF_BYPASS)) sel = SEL_BYPASS;
        else if (hit(addr, OFF_PORT))   sel = SEL_PORT;
        else if (hit(addr, OFF_FLADJ))  sel = SEL_FLADJ;
        else if (hit(addr, OFF_ENDIAN)) sel = SEL_ENDIAN;
        else if (hit(addr, OFF_COHER))  sel = SEL_COHER;
        else if (hit(addr, OFF_BME))    sel = SEL_BME;
        else if (hit(addr, OFF_STATUS)) sel = SEL_STATUS;
        else if (hit(addr, OFF_MASK))   sel = SEL_MASK;
        else if (hit(addr, OFF_EN))     sel = SEL_EN;
        else if (hit(addr, OFF_DIS))    sel = SEL_DIS;
    end
endmodule

// File: rtl/usbw_csr_cfg.sv
module usbw_csr_cfg
    import usbw_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (sel)
                SEL_BYPASS: cfg_d.bypass = wdata[BYPASS_W-1:0];
                SEL_PORT:   cfg_d.port   = wdata[PORT_W-1:0];
                SEL_FLADJ:  cfg_d.fladj  = wdata[FLADJ_W-1:0];
                SEL_ENDIAN: cfg_d.endian = wdata[0];
                SEL_COHER:  cfg_d.coher  = wdata[0];
                SEL_BME:    cfg_d.bme    = wdata[0];
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/usbw_csr_irq.sv
module usbw_csr_irq
    import usbw_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_wr,
    input  logic               en_wr,
    input  logic               dis_wr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask,
    output logic               irq
);
    irq_state_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_wr ? wdata : '0;
        // events are ORed after the clear so a same-cycle event wins
        st_d.status = (st_q.status & ~clr_bits) | evt;
        if (en_wr)       st_d.mask = st_q.mask & ~wdata;
        else if (dis_wr) st_d.mask = st_q.mask | wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;
    assign irq    = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/usbw_csr.sv
module usbw_csr
    import usbw_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic              hw_host_err,
    output logic              irq,
    output logic [3:0]        filt_bypass,
    output logic              hub_perm_attach,
    output logic              pwr_ctrl_present,
    output logic              msi_enable,
    output logic              smi_on_cmd_wr,
    output logic              smi_on_bar_wr,
    output logic [5:0]        frame_adj,
    output logic              big_endian,
    output logic              coherent_en,
    output logic              bus_master_en
);
    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    reg_sel_e           sel;
    cfg_t               cfg;
    logic               acc_ok;
    logic               wr_ok;
    logic               dec_err;
    logic [NUM_SRC-1:0] sts_vec;
    logic [NUM_SRC-1:0] msk_vec;
    logic [NUM_SRC-1:0] evt_vec;
    logic [DATA_W-1:0]  rd_mux;
    rsp_t               rsp_d, rsp_q;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:FLADJ_W];

    usbw_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign acc_ok  = bus_valid && (bus_size == SIZE_WORD);
    assign wr_ok   = acc_ok && bus_write;
    assign dec_err = acc_ok && (sel == SEL_NONE);
    assign evt_vec = {hw_host_err, dec_err};

    usbw_csr_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    usbw_csr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_wr (wr_ok && sel == SEL_STATUS),
        .en_wr  (wr_ok && sel == SEL_EN),
        .dis_wr (wr_ok && sel == SEL_DIS),
        .wdata  (bus_wdata[NUM_SRC-1:0]),
        .evt    (evt_vec),
        .status (sts_vec),
        .mask   (msk_vec),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_BYPASS: rd_mux = DATA_W'(cfg.bypass);
            SEL_PORT:   rd_mux = DATA_W'(cfg.port);
            SEL_FLADJ:  rd_mux = DATA_W'(cfg.fladj);
            SEL_ENDIAN: rd_mux = DATA_W'(cfg.endian);
            SEL_COHER:  rd_mux = DATA_W'(cfg.coher);
            SEL_BME:    rd_mux = DATA_W'(cfg.bme);
            SEL_STATUS: rd_mux = DATA_W'(sts_vec);
            SEL_MASK:   rd_mux = DATA_W'(msk_vec);
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        rsp_d.rvalid = bus_valid && !bus_write;
        rsp_d.rdata  = (acc_ok && !bus_write) ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rvalid       = rsp_q.rvalid;
    assign bus_rdata        = rsp_q.rdata;
    assign filt_bypass      = cfg.bypass;
    assign hub_perm_attach  = cfg.port[0];
    assign pwr_ctrl_present = cfg.port[1];
    assign msi_enable       = cfg.port[2];
    assign smi_on_cmd_wr    = cfg.port[3];
    assign smi_on_bar_wr    = cfg.port[4];
    assign frame_adj        = cfg.fladj;
    assign big_endian       = cfg.endian;
    assign coherent_en      = cfg.coher;
    assign bus_master_en    = cfg.bme;
endmodule

// File: rtl/usbw_csr_chk.sv
module usbw_csr_chk
    import usbw_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic              hw_host_err,
    input logic              irq,
    input logic [NUM_SRC-1:0] sts_vec,
    input logic [NUM_SRC-1:0] msk_vec,
    input logic [5:0]        frame_adj,
    input logic [3:0]        filt_bypass
);
    logic good_wr;
    logic bad_sz;
    assign good_wr = bus_valid && bus_write && bus_size == SIZE_WORD;
    assign bad_sz  = bus_valid && bus_size != SIZE_WORD;

    // R5: interrupt only with an unmasked pending source
    a_r5_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((sts_vec & ~msk_vec) != '0));

    // R6: event pulse sets host error status
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hw_host_err |=> sts_vec[1]);

    // R8: enable write clears bit 0 of mask
    a_r8_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(OFF_EN) && bus_wdata[0]) |=> !msk_vec[0]);

    // R8: disable write sets bit 1 of mask
    a_r8_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(OFF_DIS) && bus_wdata[1]) |=> msk_vec[1]);

    // R2: unsupported size leaves fields untouched
    a_r2_bad_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sz |=> ($stable(frame_adj) && $stable(filt_bypass) && $stable(msk_vec)));

    // R9: mask write has no effect
    a_r9_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> $stable(msk_vec));
endmodule

bind usbw_csr usbw_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .hw_host_err (hw_host_err),
    .irq         (irq),
    .sts_vec     (sts_vec),
    .msk_vec     (msk_vec),
    .frame_adj   (frame_adj),
    .filt_bypass (filt_bypass)
);

// File: tb/usbw_csr_tb.sv
module usbw_csr_tb;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_size = 2'd2;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [31:0]       bus_rdata;
    logic              hw_host_err = 1'b0;
    logic              irq;
    logic [3:0]        filt_bypass;
    logic              hub_perm_attach, pwr_ctrl_present, msi_enable;
    logic              smi_on_cmd_wr, smi_on_bar_wr;
    logic [5:0]        frame_adj;
    logic              big_endian, coherent_en, bus_master_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd_val;
    logic        rd_vld;

    always #5 clk = ~clk;

    usbw_csr #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .hw_host_err(hw_host_err),
        .irq(irq), .filt_bypass(filt_bypass), .hub_perm_attach(hub_perm_attach),
        .pwr_ctrl_present(pwr_ctrl_present), .msi_enable(msi_enable),
        .smi_on_cmd_wr(smi_on_cmd_wr), .smi_on_bar_wr(smi_on_bar_wr),
        .frame_adj(frame_adj), .big_endian(big_endian), .coherent_en(coherent_en),
        .bus_master_en(bus_master_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                          input logic [1:0] sz, input logic evt);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = data;
        bus_size = sz; hw_host_err = evt;
        @(posedge clk);
        #1;
        rd_val = bus_rdata; rd_vld = bus_rvalid;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2; hw_host_err = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] addr, input logic [31:0] data);
        access(1'b1, addr, data, 2'd2, 1'b0);
    endtask

    task automatic rd32(input logic [7:0] addr);
        access(1'b0, addr, 32'h0, 2'd2, 1'b0);
    endtask

    task automatic t_reset;
        rd32(8'h68); check("R1 mask", rd_val, 32'h3);
        rd32(8'h64); check("R1 status", rd_val, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 outputs", {frame_adj, filt_bypass, big_endian, coherent_en, bus_master_en,
              hub_perm_attach, pwr_ctrl_present, msi_enable, smi_on_cmd_wr, smi_on_bar_wr}, 32'h0);
    endtask

    task automatic t_cfg;
        wr32(8'h30, 32'hFFFF_FFFF);
        check("R3 bypass port", {28'b0, filt_bypass}, 32'hF);
        rd32(8'h30); check("R3 bypass read", rd_val, 32'hF);
        check("R11 rvalid", {31'b0, rd_vld}, 32'h1);
        wr32(8'h38, 32'hFFFF_FFE5);
        check("R3 fladj port", {26'b0, frame_adj}, 32'h25);
        rd32(8'h38); check("R3 fladj read", rd_val, 32'h25);
        wr32(8'h40, 32'h3); wr32(8'h44, 32'h1); wr32(8'h48, 32'h1);
        check("R3 single bits", {29'b0, big_endian, coherent_en, bus_master_en}, 32'h7);
        rd32(8'h40); check("R3 endian read", rd_val, 32'h1);
        wr32(8'h44, 32'h0);
        check("R3 coherency clear", {31'b0, coherent_en}, 32'h0);
    endtask

    task automatic t_port;
        wr32(8'h34, 32'h0000_0005);
        check("R4 port bits 0,2", {27'b0, smi_on_bar_wr, smi_on_cmd_wr, msi_enable,
              pwr_ctrl_present, hub_perm_attach}, 32'h05);
        wr32(8'h34, 32'hFFFF_FFFA);
        check("R4 port bits 1,3,4", {27'b0, smi_on_bar_wr, smi_on_cmd_wr, msi_enable,
              pwr_ctrl_present, hub_perm_attach}, 32'h1A);
        rd32(8'h34); check("R4 port read", rd_val, 32'h1A);
    endtask

    task automatic t_size;
        access(1'b1, 8'h38, 32'h0, 2'd1, 1'b0);
        check("R2 narrow write ignored", {26'b0, frame_adj}, 32'h25);
        access(1'b0, 8'h38, 32'h0, 2'd3, 1'b0);
        check("R2 wide read zero", rd_val, 32'h0);
        access(1'b0, 8'h7C, 32'h0, 2'd0, 1'b0);
        rd32(8'h64); check("R2 no decode error", rd_val, 32'h0);
    endtask

    task automatic t_decode;
        rd32(8'h7C); check("R10 unmapped read zero", rd_val, 32'h0);
        check("R10 masked no irq", {31'b0, irq}, 32'h0);
        rd32(8'h64); check("R10 status bit0", rd_val, 32'h1);
        wr32(8'h64, 32'h1);
        wr32(8'h31, 32'h5);
        rd32(8'h64); check("R10 unaligned write", rd_val, 32'h1);
        check("R10 bypass unchanged", {28'b0, filt_bypass}, 32'hF);
        wr32(8'h64, 32'h1);
    endtask

    task automatic t_irq;
        rd32(8'h7C);
        wr32(8'h6C, 32'h1);
        check("R8 enable clears mask -> irq", {31'b0, irq}, 32'h1);
        rd32(8'h68); check("R8 mask after enable", rd_val, 32'h2);
        rd32(8'h6C); check("R8 enable reads zero", rd_val, 32'h0);
        wr32(8'h68, 32'h3);
        rd32(8'h68); check("R9 mask read-only", rd_val, 32'h2);
        rd32(8'h64); check("R9 no decode error", rd_val, 32'h1);
        wr32(8'h64, 32'h2);
        check("R7 clear other bit keeps irq", {31'b0, irq}, 32'h1);
        wr32(8'h64, 32'h1);
        check("R7 W1C drops irq", {31'b0, irq}, 32'h0);
        wr32(8'h70, 32'h1);
        rd32(8'h68); check("R8 disable sets mask", rd_val, 32'h3);
        rd32(8'h70); check("R8 disable reads zero", rd_val, 32'h0);
    endtask

    task automatic t_event;
        @(negedge clk); hw_host_err = 1'b1;
        @(negedge clk); hw_host_err = 1'b0;
        check("R5 masked event no irq", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd32(8'h64); check("R6 status bit1 held", rd_val, 32'h2);
        wr32(8'h6C, 32'h2);
        check("R5 unmask -> irq", {31'b0, irq}, 32'h1);
        access(1'b1, 8'h64, 32'h2, 2'd2, 1'b1);
        rd32(8'h64); check("R7 event wins over clear", rd_val, 32'h2);
        check("R7 irq stays", {31'b0, irq}, 32'h1);
        wr32(8'h64, 32'h2);
        rd32(8'h64); check("R7 cleared", rd_val, 32'h0);
        check("R5 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #200_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_port();
        t_size();
        t_decode();
        t_irq();
        t_event();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule